// File: doc/BRIEF.md
# SPI Byte-Addressed Register Memory Target

This block is a serial-bus target that fronts a 512-byte memory built from on-chip registers. A host selects it with an active-low chip select and then clocks in a command byte, an optional address byte and any number of data bytes. The host can also clock read data back out on a separate data line. The host serial clock, chip select and data input are asynchronous to the block. They are synchronised into a faster system clock, and all protocol work runs on edge pulses in that domain.

Each select carries exactly one command. Two commands arm and disarm a write-enable latch. Two more read and write a small status byte that holds the latch state and two protect bits. The memory commands take the ninth address bit from the command byte itself and the low eight bits from the byte that follows. Reads and writes then step through the array with automatic increment, and the address wraps at the top. Writes take effect as each byte completes, so the host never waits for a busy flag. Idle clock level may be low (mode 0) or high (mode 3). In both modes bits are taken on rising clock edges.

Top module: `spi_mem_target`

## Requirements
- R1: Command 0x05 returns the status byte MSB first: bits 7:4 and bit 0 read as zero, bits 3:2 are the protect code and bit 1 is the write-enable latch. The status byte repeats for as long as the host keeps clocking.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Both are complete after one byte.
- R3: A read command has the form 0000_A011. Bit 3 (A) is address bit 8, and the next byte gives address bits 7:0. Data for that address is then shifted out MSB first, with each bit changing on a falling clock edge.
- R4: During a read the address advances after every byte and wraps from 0x1FF to 0x000.
- R5: A write command has the form 0000_A010, with the address formed as in R3. Each fully received data byte is stored, then the address advances and wraps as in R4. A byte is stored only while the latch is set. A stored byte is returned by the next read, with no busy interval.
- R6: A data byte that is cut short by chip select rising is discarded.
- R7: The write-enable latch is cleared when chip select rises after a write command or a status-write command, whether or not anything was stored.
- R8: Command 0x01 loads data bits 3:2 into the protect code, but only while the latch is set. Protect code 01 blocks writes to 0x180–0x1FF, code 10 blocks 0x100–0x1FF, code 11 blocks the whole array, and code 00 blocks nothing.
- R9: Only the first byte of a select is decoded as a command. Bytes after a finished command, and every byte after an unknown command, have no effect until chip select rises.
- R10: Mode 0 (clock idle low) and mode 3 (clock idle high) both work. In mode 3 the falling edge that comes before the first rising edge carries no data.
- R11: The data output enable is low while chip select is inactive and high while it is active, two system clocks behind the pin. The data output is low whenever its enable is low.
- R12: After reset the latch is clear, the protect code is 00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for miso |

## Verification
The bench builds the block with its default 8-bit data width, which gives a 9-bit address, and with two synchroniser stages. With these values the address step across 0x0FF to 0x100 exercises the command-carried ninth bit, and the 0x1FF to 0x000 wrap falls within a short burst. Each protect region ends one byte from an unprotected neighbour, so both sides of every region are checked in a single write. The two-stage synchroniser fixes the enable delay that the reference model follows on every clock, and it leaves enough margin for eight-clock half periods of the serial clock in both modes.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic [2:0] {
    ST_OP,     // waiting for the command byte
    ST_ADDR,   // collecting low address byte
    ST_WDATA,  // storing data bytes
    ST_RDATA,  // shifting memory bytes out
    ST_SRD,    // shifting status byte out
    ST_SWR,    // taking the status byte
    ST_MUTE    // command finished or unknown: ignore until deselect
  } smt_state_e;

  localparam logic [7:0] CMD_LATCH_SET = 8'h06;
  localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;

  function automatic logic is_mem_rd(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
  endfunction

  function automatic logic is_mem_wr(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
  endfunction

endpackage

// File: rtl/smt_sync.sv
module smt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_end,
  output logic sel_act,
  output logic mosi_s
);

  logic [STAGES-1:0] sck_q, sck_n;
  logic [STAGES-1:0] cs_q, cs_n;
  logic [STAGES-1:0] dat_q, dat_n;
  logic              sck_d_q, cs_d_q;
  logic              sck_s, cs_s;

  always_comb begin
    sck_n = {sck_q[STAGES-2:0], sck_i};
    cs_n  = {cs_q[STAGES-2:0], cs_n_i};
    dat_n = {dat_q[STAGES-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= '0;
      cs_q    <= '1;
      dat_q   <= '0;
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      sck_q   <= sck_n;
      cs_q    <= cs_n;
      dat_q   <= dat_n;
      sck_d_q <= sck_s;
      cs_d_q  <= cs_s;
    end
  end

  assign sck_s    = sck_q[STAGES-1];
  assign cs_s     = cs_q[STAGES-1];
  assign mosi_s   = dat_q[STAGES-1];
  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign sel_act  = ~cs_s;
  assign sel_end  = cs_s & ~cs_d_q;

endmodule

// File: rtl/smt_mem.sv
module smt_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cell_q[addr] <= wdata;
    end
  end

  assign rdata = cell_q[addr];

endmodule

// File: rtl/smt_cmd.sv
module smt_cmd
  import smt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W + 1,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel_end,
  input  logic              sel_act,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              miso_bit
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  smt_state_e        state_q, state_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [BIT_W-1:0]  ocnt_q, ocnt_n;
  logic [DATA_W-2:0] sh_q, sh_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              ahi_q, ahi_n;
  logic              rdcmd_q, rdcmd_n;
  logic              wel_q, wel_n;
  logic              drop_q, drop_n;
  logic [1:0]        bp_q, bp_n;

  logic              rise, fall, byte_done, blocked;
  logic [DATA_W-1:0] byte_in, stat_byte;

  assign rise      = sck_rise & sel_act;
  assign fall      = sck_fall & sel_act;
  assign byte_in   = {sh_q, mosi_s};
  assign byte_done = rise && (bit_q == LAST_BIT);
  assign stat_byte = {{(DATA_W-4){1'b0}}, bp_q, wel_q, 1'b0};

  always_comb begin
    unique case (bp_q)
      2'b01:   blocked = (addr_q[ADDR_W-1:ADDR_W-2] == 2'b11);
      2'b10:   blocked = addr_q[ADDR_W-1];
      2'b11:   blocked = 1'b1;
      default: blocked = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    ocnt_n  = ocnt_q;
    sh_n    = sh_q;
    out_n   = out_q;
    addr_n  = addr_q;
    ahi_n   = ahi_q;
    rdcmd_n = rdcmd_q;
    wel_n   = wel_q;
    drop_n  = drop_q;
    bp_n    = bp_q;
    mem_we  = 1'b0;

    if (!sel_act) begin
      state_n = ST_OP;
      bit_n   = '0;
      ocnt_n  = '0;
      drop_n  = 1'b0;
      if (sel_end && drop_q) begin
        wel_n = 1'b0;
      end
    end else begin
      if (rise) begin
        sh_n  = byte_in[DATA_W-2:0];
        bit_n = bit_q + BIT_W'(1);
      end

      if (byte_done) begin
        unique case (state_q)
          ST_OP: begin
            if (byte_in == CMD_LATCH_SET) begin
              wel_n   = 1'b1;
              state_n = ST_MUTE;
            end else if (byte_in == CMD_LATCH_CLR) begin
              wel_n   = 1'b0;
              state_n = ST_MUTE;
            end else if (byte_in == CMD_STAT_RD) begin
              ocnt_n  = '0;
              state_n = ST_SRD;
            end else if (byte_in == CMD_STAT_WR) begin
              drop_n  = 1'b1;
              state_n = ST_SWR;
            end else if (is_mem_rd(byte_in)) begin
              ahi_n   = byte_in[3];
              rdcmd_n = 1'b1;
              state_n = ST_ADDR;
            end else if (is_mem_wr(byte_in)) begin
              ahi_n   = byte_in[3];
              rdcmd_n = 1'b0;
              drop_n  = 1'b1;
              state_n = ST_ADDR;
            end else begin
              state_n = ST_MUTE;
            end
          end
          ST_ADDR: begin
            addr_n  = {ahi_q, byte_in};
            ocnt_n  = '0;
            state_n = rdcmd_q ? ST_RDATA : ST_WDATA;
          end
          ST_WDATA: begin
            mem_we = wel_q & ~blocked;
            addr_n = addr_q + ADDR_W'(1);
          end
          ST_SWR: begin
            if (wel_q) begin
              bp_n = byte_in[3:2];
            end
            state_n = ST_MUTE;
          end
          default: ;
        endcase
      end

      if (fall && ((state_q == ST_RDATA) || (state_q == ST_SRD))) begin
        if (ocnt_q == '0) begin
          if (state_q == ST_RDATA) begin
            out_n  = rd_data;
            addr_n = addr_q + ADDR_W'(1);
          end else begin
            out_n  = stat_byte;
          end
        end else begin
          out_n = {out_q[DATA_W-2:0], 1'b0};
        end
        ocnt_n = ocnt_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      bit_q   <= '0;
      ocnt_q  <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      addr_q  <= '0;
      ahi_q   <= 1'b0;
      rdcmd_q <= 1'b0;
      wel_q   <= 1'b0;
      drop_q  <= 1'b0;
      bp_q    <= 2'b00;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      ocnt_q  <= ocnt_n;
      sh_q    <= sh_n;
      out_q   <= out_n;
      addr_q  <= addr_n;
      ahi_q   <= ahi_n;
      rdcmd_q <= rdcmd_n;
      wel_q   <= wel_n;
      drop_q  <= drop_n;
      bp_q    <= bp_n;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = byte_in;
  assign miso_bit  = out_q[DATA_W-1];

  // R5: a store only happens in the data phase with the latch armed
  p_store_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wel_q && (state_q == ST_WDATA)));

  // R8: no store lands inside the region chosen by the protect code
  p_protect_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((bp_q == 2'b00) ||
                ((bp_q == 2'b01) && (addr_q < ADDR_W'(3 << (ADDR_W-2)))) ||
                ((bp_q == 2'b10) && (addr_q < ADDR_W'(1 << (ADDR_W-1))))));

  // R7: deselect after a write-type command leaves the latch clear
  p_latch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && drop_q) |=> !wel_q);

  // R9: once past the command byte, decode never restarts inside a select
  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act && (state_q != ST_OP)) |=> (state_q != ST_OP));

  // R6: a deselect discards any partly received byte
  p_partial_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (bit_q == '0));

  // R8: protect code cannot move while deselected
  p_bp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> $stable(bp_q));

endmodule

// File: rtl/spi_mem_target.sv
module spi_mem_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W + 1,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);

  logic [1:0]        rst_q;
  logic              rst_sn;
  logic              sck_rise, sck_fall, sel_end, sel_act, mosi_s;
  logic              mem_we, miso_bit;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_q[1];

  smt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_sn),
    .sck_i    (sck),
    .cs_n_i   (cs_n),
    .mosi_i   (mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sel_end  (sel_end),
    .sel_act  (sel_act),
    .mosi_s   (mosi_s)
  );

  smt_cmd #(.DATA_W(DATA_W)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_sn),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel_end   (sel_end),
    .sel_act   (sel_act),
    .mosi_s    (mosi_s),
    .rd_data   (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .miso_bit  (miso_bit)
  );

  smt_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign miso_oe = sel_act;
  assign miso    = sel_act & miso_bit;

  generate
    if (SYNC_STAGES == 2) begin : g_oe_chk
      // R11: chip select held high at the pin forces the enable low
      p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_sn)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_oe);
    end
  endgenerate

  // R11: data line quiet whenever its enable is low
  p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !miso_oe |-> !miso);

endmodule

// File: tb/test_spi_mem_target.sv
module test_spi_mem_target;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit mode3 = 1'b0;
  bit run_oe = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0] ref_mem [512];
  bit         known [512];
  bit         ref_wel = 1'b0;
  logic [1:0] ref_bp = 2'b00;
  logic       c1 = 1'b1, c2 = 1'b1;

  spi_mem_target i_spi_mem_target (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // enable follows chip select two clocks late (R11)
  always @(posedge clk) begin
    c2 <= c1;
    c1 <= cs_n;
  end

  always @(negedge clk) begin
    if (run_oe && !done) begin
      n_chk++;
      if (miso_oe !== !c2) begin
        n_fail++;
        $display("FAIL R11 actual %0b expected %0b", miso_oe, !c2);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit prot(input int a);
    case (ref_bp)
      2'b01:   return a >= 'h180;
      2'b10:   return a >= 'h100;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sel_on();
    sck = mode3;
    wclk(H);
    cs_n = 1'b0;
    wclk(H);
  endtask

  task automatic sel_off();
    if (!mode3) begin
      sck = 1'b0;
      wclk(H);
    end
    cs_n = 1'b1;
    wclk(2 * H);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sck  = 1'b0;
      mosi = b[i];
      wclk(H);
      r[i] = miso;
      sck  = 1'b1;
      wclk(H);
    end
  endtask

  task automatic part_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck  = 1'b0;
      mosi = b[i];
      wclk(H);
      sck  = 1'b1;
      wclk(H);
    end
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [7:0] r;
    sel_on();
    xfer(c, r);
    sel_off();
    if (c == 8'h06) ref_wel = 1'b1;
    if (c == 8'h04) ref_wel = 1'b0;
  endtask

  task automatic rd_status(input string req);
    logic [7:0] r;
    sel_on();
    xfer(8'h05, r);
    xfer(8'h00, r);
    chk(req, r, {4'h0, ref_bp, ref_wel, 1'b0});
    xfer(8'h00, r);
    chk(req, r, {4'h0, ref_bp, ref_wel, 1'b0});
    sel_off();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r;
    sel_on();
    xfer(8'h01, r);
    xfer(v, r);
    sel_off();
    if (ref_wel) ref_bp = v[3:2];
    ref_wel = 1'b0;
  endtask

  task automatic mem_wr(input int a0, input int n, input logic [7:0] base,
                        input int extra);
    logic [7:0] r, d;
    int a;
    a = a0;
    sel_on();
    xfer({4'h0, a0[8], 3'b010}, r);
    xfer(a0[7:0], r);
    for (int k = 0; k < n; k++) begin
      d = base ^ 8'(k * 37);
      xfer(d, r);
      if (ref_wel && !prot(a)) begin
        ref_mem[a] = d;
        known[a] = 1'b1;
      end
      a = (a + 1) % 512;
    end
    if (extra > 0) part_bits(~base, extra);
    sel_off();
    ref_wel = 1'b0;
  endtask

  task automatic mem_rd(input string req, input int a0, input int n);
    logic [7:0] r;
    int a;
    a = a0;
    sel_on();
    xfer({4'h0, a0[8], 3'b011}, r);
    xfer(a0[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      if (known[a]) chk(req, r, ref_mem[a]);
      a = (a + 1) % 512;
    end
    sel_off();
  endtask

  initial begin
    logic [7:0] r;
    wclk(10);
    rst_n = 1'b1;
    wclk(10);
    run_oe = 1'b1;

    // R12: reset state
    chk("R12", miso_oe, 0);
    rd_status("R12");

    // R2 / R1: latch set and clear
    cmd1(8'h06);
    rd_status("R1");
    cmd1(8'h04);
    rd_status("R2");

    // R3 / R5 / R7: write across the A8 boundary, read back
    cmd1(8'h06);
    mem_wr('h0FE, 4, 8'hA0, 0);
    rd_status("R7");
    mem_rd("R3", 'h0FE, 4);

    // R5: write with latch clear stores nothing
    mem_wr('h0FE, 2, 8'h11, 0);
    mem_rd("R5", 'h0FE, 2);

    // R4: wrap at top of array
    cmd1(8'h06);
    mem_wr('h1FE, 4, 8'h30, 0);
    mem_rd("R4", 'h1FE, 4);

    // R6: truncated last byte discarded
    cmd1(8'h06);
    mem_wr('h010, 3, 8'h5C, 0);
    cmd1(8'h06);
    mem_wr('h010, 1, 8'hC3, 5);
    mem_rd("R6", 'h010, 3);

    // R8: protect regions
    cmd1(8'h06);
    mem_wr('h17E, 4, 8'h70, 0);
    cmd1(8'h06);
    wr_status(8'h04);
    rd_status("R8");
    cmd1(8'h06);
    mem_wr('h17E, 4, 8'h90, 0);
    mem_rd("R8", 'h17E, 4);
    cmd1(8'h06);
    wr_status(8'h08);
    cmd1(8'h06);
    mem_wr('h0FE, 4, 8'hE0, 0);
    mem_rd("R8", 'h0FE, 4);
    cmd1(8'h06);
    wr_status(8'h0C);
    cmd1(8'h06);
    mem_wr('h000, 2, 8'h42, 0);
    mem_rd("R8", 'h000, 2);
    wr_status(8'h00);
    rd_status("R8");
    cmd1(8'h06);
    wr_status(8'h00);
    rd_status("R7");

    // R9: unknown command and trailing bytes ignored
    sel_on();
    xfer(8'h55, r);
    xfer(8'h06, r);
    sel_off();
    rd_status("R9");
    sel_on();
    xfer(8'h06, r);
    xfer(8'h04, r);
    sel_off();
    ref_wel = 1'b1;
    rd_status("R9");
    cmd1(8'h04);

    // R10: mode 3 traffic, then mode 0 cross-read
    mode3 = 1'b1;
    cmd1(8'h06);
    rd_status("R10");
    mem_wr('h0A0, 3, 8'h21, 0);
    mem_rd("R10", 'h0A0, 3);
    mode3 = 1'b0;
    mem_rd("R10", 'h0A1, 2);

    wclk(4);
    chk("R11", miso_oe, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule